// File: doc/BRIEF.md
# Two-Segment Cascaded LFSR Random Word Generator

This block produces a pseudo-random word from two Fibonacci linear-feedback shift registers joined end to end. The low segment shifts on every enabled clock. The high segment shifts only when the low segment has run through its whole period. The high segment therefore behaves like a slowly counting digit above a fast one. The output word is the two segment states side by side, with the high segment in the upper bits.

Everything runs on one clock. A cycle counter modulo 2^W1-1 produces a single-cycle enable for the high segment, so no derived or gated clock is needed. A seed can be loaded at any time. A segment whose seed half is all zero takes a fixed nonzero default instead, which keeps either register out of the locked all-zero state. The widths are parameters. The default split of 16+16 gives a 32-bit word, and a 32+32 split gives 64 bits.

Top module: `fib2_rng`

## Requirements
- R1: After synchronous reset, the low half of `word` equals DEF_LO and the high half equals DEF_HI (both default 1), and `valid` is 0.
- R2: On each enabled cycle (`run`=1, `load`=0), the low segment shifts one place toward its MSB. A new bit 0 enters, equal to the XOR of its tap bits. For a 4-bit segment the taps are bits 3 and 2.
- R3: The low segment has maximal length. A 4-bit low segment passes through all 15 nonzero states in 15 enabled cycles and never reaches zero.
- R4: The high segment shifts in the same Fibonacci form only on the enabled cycle that completes each group of 2^W1-1 enabled cycles. The first such step comes exactly 2^W1-1 enabled cycles after reset or a load. For a 3-bit high segment the taps are bits 2 and 1.
- R5: `word` is {high segment, low segment}. The combined sequence repeats after (2^W1-1)*(2^W2-1) enabled cycles, which is 105 for a 4+3 split.
- R6: While `run`=0 and `load`=0, `word` and the step counter hold and `valid` is 0.
- R7: `valid` is 1 in the cycle after each enabled cycle, when `word` shows the freshly stepped value.
- R8: `load`=1 copies `seed` into both segments and clears the step counter, with priority over `run`. Any segment whose seed half is zero takes its default instead. `valid` is 0 after a load.
- R9: In the default 16+16 configuration, the low segment uses taps 15, 14, 12 and 3 and steps from DEF_LO while the high half stays at DEF_HI for the first 2^16-2 enabled cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Load `seed` into both segments |
| seed | input | W1+W2 | Seed value: high half for the upper segment, low half for the lower |
| run | input | 1 | Step enable |
| word | output | W1+W2 | Concatenated segment state |
| valid | output | 1 | `word` was just stepped |

## Verification
A corrupted step counter shows up at the upper bits. The high half either changes too early or stays still past the enabled cycle that closes a low-segment period, so the error is visible within at most 2^W1-1 enabled cycles. A wrong tap or shift in either segment shows as a wrong value on `word` at the very next step of that segment. A seed substitution fault shows in the cycle right after the load.

// File: rtl/fib2_rng.sv
module fib2_rng #(
  parameter int W1 = 16,
  parameter int W2 = 16,
  parameter logic [W1-1:0] DEF_LO = 1,
  parameter logic [W2-1:0] DEF_HI = 1,
  localparam int W = W1 + W2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] seed,
  input  logic         run,
  output logic [W-1:0] word,
  output logic         valid
);

  function automatic logic [63:0] taps(input int n);
    case (n)
      3:  return 64'h6;
      4:  return 64'hC;
      5:  return 64'h14;
      6:  return 64'h30;
      7:  return 64'h60;
      8:  return 64'hB8;
      12: return 64'h829;
      16: return 64'hD008;
      24: return 64'hE10000;
      32: return 64'h80200003;
      64: return 64'hD800000000000000;
      default: return 64'h0;
    endcase
  endfunction

  localparam logic [63:0] T1 = taps(W1);
  localparam logic [63:0] T2 = taps(W2);
  localparam logic [W1-1:0] LAST = {{(W1-1){1'b1}}, 1'b0};

  logic [W1-1:0] lo;
  logic [W2-1:0] hi;
  logic [W1-1:0] cnt;
  logic          step, wrap;
  logic [W1-1:0] seed_lo;
  logic [W2-1:0] seed_hi;

  assign seed_lo = seed[W1-1:0];
  assign seed_hi = seed[W-1:W1];
  assign step    = run && !load;
  assign wrap    = (cnt == LAST);
  assign word    = {hi, lo};

  always_ff @(posedge clk) begin
    if (rst) begin
      lo    <= DEF_LO;
      hi    <= DEF_HI;
      cnt   <= '0;
      valid <= 1'b0;
    end else if (load) begin
      lo    <= (seed_lo == '0) ? DEF_LO : seed_lo;
      hi    <= (seed_hi == '0) ? DEF_HI : seed_hi;
      cnt   <= '0;
      valid <= 1'b0;
    end else begin
      valid <= step;
      if (step) begin
        lo <= {lo[W1-2:0], ^(lo & T1[W1-1:0])};
        if (wrap) begin
          cnt <= '0;
          hi  <= {hi[W2-2:0], ^(hi & T2[W2-1:0])};
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/fib2_rng_chk.sv
module fib2_rng_chk #(
  parameter int W1 = 16,
  parameter int W2 = 16,
  parameter logic [W1-1:0] DEF_LO = 1,
  parameter logic [W2-1:0] DEF_HI = 1,
  localparam int W = W1 + W2
) (
  input logic         clk,
  input logic         rst,
  input logic         load,
  input logic [W-1:0] seed,
  input logic         run,
  input logic [W-1:0] word,
  input logic         valid
);
  localparam logic [W1-1:0] LAST = {{(W1-1){1'b1}}, 1'b0};
  logic [W1-1:0] n;

  always_ff @(posedge clk) begin
    if (rst || load) n <= '0;
    else if (run) n <= (n == LAST) ? '0 : n + 1'b1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (word == {DEF_HI, DEF_LO}) && !valid);

  // R2
  lo_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> word[W1-1:1] == $past(word[W1-2:0]));

  // R3
  lo_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    word[W1-1:0] != '0);

  // R4
  hi_still_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !load && n != LAST) |=> $stable(word[W-1:W1]));

  // R4
  hi_step_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !load && n == LAST) |=> word[W-1:W1+1] == $past(word[W-2:W1]));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !load) |=> $stable(word) && !valid);

  // R7
  valid_chk: assert property (@(posedge clk) disable iff (rst)
    (run && !load) |=> valid);

  // R8
  load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> !valid && (word[W1-1:0] == (($past(seed[W1-1:0]) == '0) ? DEF_LO : $past(seed[W1-1:0]))));
endmodule

bind fib2_rng fib2_rng_chk #(.W1(W1), .W2(W2), .DEF_LO(DEF_LO), .DEF_HI(DEF_HI)) u_chk (
  .clk(clk), .rst(rst), .load(load), .seed(seed), .run(run), .word(word), .valid(valid));

// File: tb/sim_fib2_rng.sv
`timescale 1ns/1ps
module sim_fib2_rng;
  logic clk = 0;
  always #4 clk = ~clk;

  logic rst, load, run;
  logic [6:0] seed;
  logic [6:0] word;
  logic valid;

  logic rst1, run1;
  logic [31:0] word1;
  logic valid1;

  int checks = 0, fails = 0;
  logic [3:0] m1;
  logic [2:0] m2;
  int mc;

  fib2_rng #(.W1(4), .W2(3)) u0 (.clk(clk), .rst(rst), .load(load), .seed(seed),
    .run(run), .word(word), .valid(valid));
  fib2_rng u1 (.clk(clk), .rst(rst1), .load(1'b0), .seed(32'h0),
    .run(run1), .word(word1), .valid(valid1));

  function automatic logic [3:0] nx1(input logic [3:0] x); return {x[2:0], x[3]^x[2]}; endfunction
  function automatic logic [2:0] nx2(input logic [2:0] x); return {x[1:0], x[2]^x[1]}; endfunction
  function automatic logic [15:0] nx16(input logic [15:0] x);
    return {x[14:0], x[15]^x[14]^x[12]^x[3]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    if (rst) begin m1 = 4'd1; m2 = 3'd1; mc = 0; end
    else if (load) begin
      m1 = (seed[3:0] == 0) ? 4'd1 : seed[3:0];
      m2 = (seed[6:4] == 0) ? 3'd1 : seed[6:4];
      mc = 0;
    end else if (run) begin
      m1 = nx1(m1);
      if (mc == 14) begin mc = 0; m2 = nx2(m2); end else mc++;
    end
    #1;
  endtask

  task automatic check_word(input string req);
    chk(word === {m2, m1}, req, word, {m2, m1});
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] seen;
    logic [6:0] start, prev;
    logic [15:0] r;
    rst = 1; load = 0; run = 0; seed = 0; rst1 = 1; run1 = 0;
    tick(); tick();
    // R1 reset state
    chk(word === 7'h11, "R1", word, 7'h11);
    chk(valid === 1'b0, "R1 valid", valid, 0);
    rst = 0;
    start = word;
    seen = 16'h0;
    run = 1;
    for (int i = 1; i <= 105; i++) begin
      prev = word;
      tick();
      check_word("R2/R4 sequence");
      chk(valid === 1'b1, "R7", valid, 1);
      if (i <= 15) seen[word[3:0]] = 1'b1;
      if (i == 14) chk(word[6:4] === prev[6:4], "R4 no early step", word[6:4], prev[6:4]);
      if (i == 15) chk(word[6:4] === nx2(prev[6:4]), "R4 first step", word[6:4], nx2(prev[6:4]));
      if (i < 105) chk(i % 15 == 0 || word !== start, "R5 early repeat", word, start);
    end
    // R3 maximal low segment
    chk(seen === 16'hFFFE, "R3", seen, 16'hFFFE);
    // R5 full period
    chk(word === start, "R5 period", word, start);
    // R6 hold
    for (int i = 0; i < 7; i++) begin tick(); check_word("R2"); end
    run = 0;
    prev = word;
    for (int i = 0; i < 5; i++) begin
      tick();
      chk(word === prev, "R6 hold", word, prev);
      chk(valid === 1'b0, "R6 valid", valid, 0);
    end
    run = 1;
    for (int i = 0; i < 20; i++) begin tick(); check_word("R6 resume"); end
    // R8 load with run high
    load = 1; seed = 7'b101_1001;
    tick();
    chk(word === 7'b101_1001, "R8 load", word, 7'b101_1001);
    chk(valid === 1'b0, "R8 valid", valid, 0);
    load = 0;
    for (int i = 1; i <= 15; i++) begin
      prev = word;
      tick();
      check_word("R8 counter cleared");
      if (i == 15) chk(word[6:4] === 3'b011, "R8/R4 first step after load", word[6:4], 3'b011);
    end
    load = 1; seed = 7'h00; tick();
    chk(word === 7'h11, "R8 zero seed", word, 7'h11);
    seed = 7'b110_0000; tick();
    chk(word === 7'b110_0001, "R8 zero low half", word, 7'b110_0001);
    seed = 7'b000_0110; tick();
    chk(word === 7'b001_0110, "R8 zero high half", word, 7'b001_0110);
    load = 0; run = 0; seed = 7'h7F; tick();
    chk(word === 7'b001_0110, "R8 seed ignored without load", word, 7'b001_0110);
    run = 1;
    for (int i = 0; i < 30; i++) begin tick(); check_word("R4 after load"); end
    rst = 1; tick(); rst = 0;
    chk(word === 7'h11, "R1 mid-run reset", word, 7'h11);
    chk(valid === 1'b0, "R1 mid-run valid", valid, 0);
    // R9 default 16+16
    run = 0; rst1 = 0; run1 = 1;
    r = 16'd1;
    for (int i = 0; i < 40; i++) begin
      tick();
      r = nx16(r);
      chk(word1 === {16'd1, r}, "R9", word1, {16'd1, r});
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule